// File: doc/BRIEF.md
# Circular Receive Buffer Writer

This block places received frames into a byte-addressed ring in memory. It is the plain alternative to a descriptor-driven receive path. A frame is offered with its byte count and three address-class flags: broadcast, station match and multicast. The block first decides whether the ring has room. If it does, it writes a 32-bit status-and-length word, then the frame bytes one at a time, then a 32-bit check word. Every address wraps at the end of the ring. When the frame is complete, the device write pointer moves up to the next 4-byte boundary.

The host owns the read pointer and presents it on an input. The host side that drains the ring is outside this block. A frame that does not fit is dropped without any write to memory. The drop raises a one-cycle overflow interrupt pulse and increments a missed-frame counter. A stored frame raises a one-cycle receive-OK pulse.

The ring size is a power-of-two parameter. Its default is 8192 bytes. The check word is either a CRC-32 of the frame bytes or zero, chosen by a parameter.

Top module: `rxb_ring_writer`

## Requirements
- R1: After reset the write pointer is 0, the missed counter is 0, `busy` is low and no memory write is issued.
- R2: At frame start, free space is (read pointer − write pointer) modulo the ring size. When that value is nonzero and the length plus 8 is greater than or equal to it, the frame is dropped. A drop issues no memory write, pulses `irq_rx_ovf` for exactly the one cycle after the start, and increments `miss_cnt` by one.
- R3: When the read pointer equals the write pointer, the free space counts as zero and the frame is always accepted.
- R4: The first write of an accepted frame is one word write (`mem_wide`=1) at the write pointer. In that word, bit 0 is 1, bit 13 is the broadcast flag, bit 14 is the station-match flag, bit 15 is the multicast flag, and bits 31:16 hold the length plus 4. The word is stored little-endian.
- R5: Frame bytes are written in arrival order, one byte write each, at consecutive addresses modulo the ring size, so a frame may straddle the end of the ring.
- R6: After the last frame byte, four byte writes store the check word least significant byte first. With the CRC option enabled, the check word is the standard reflected CRC-32 of the frame bytes (polynomial 0xEDB88320, initial value all ones, final inversion). Otherwise it is zero.
- R7: After the check word, the write pointer is (old pointer + length + 8) rounded up to a multiple of 4, modulo the ring size.
- R8: `irq_rx_ok` is high for exactly one cycle: the first cycle in which `busy` is low again after a stored frame.
- R9: `frm_start` is ignored while `busy` is high. `byte_valid` is ignored unless `dat_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_ptr | input | PTR_W | Host read pointer (byte offset into the ring) |
| frm_start | input | 1 | Offers a new frame; length and flags are sampled in the same cycle |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_kind | input | 3 | Bit 0 broadcast, bit 1 station match, bit 2 multicast |
| byte_valid | input | 1 | A frame byte is present on `byte_data` |
| byte_data | input | 8 | Frame byte |
| busy | output | 1 | A frame is being stored |
| dat_rdy | output | 1 | A byte on `byte_data` is taken this cycle if `byte_valid` is high |
| mem_we | output | 1 | Memory write strobe |
| mem_wide | output | 1 | 1: 32-bit word write; 0: single byte in bits 7:0 |
| mem_addr | output | PTR_W | Write address in the ring |
| mem_wdata | output | 32 | Write data |
| wr_ptr | output | PTR_W | Device write pointer |
| miss_cnt | output | MISS_W | Number of dropped frames, wrapping |
| irq_rx_ok | output | 1 | One-cycle pulse when a frame has been stored |
| irq_rx_ovf | output | 1 | One-cycle pulse when a frame has been dropped for lack of space |

## Verification
The properties assume two things about the inputs. First, the host read pointer holds still while a frame is being stored. Second, a frame start carries a length the block can hold: the length plus 4 fits in the 16-bit header field. The bench meets both. It changes `rd_ptr` only while `busy` is low, and it uses lengths of 4095 bytes or less. The bench places the read pointer relative to the modelled write pointer, so every space case (empty, exact-fit drop, one byte to spare) is reached on purpose. Frames that cross the end of the ring are produced by advancing the pointer with accepted frames on an empty ring.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HDR   = 2'd1,
      ST_DATA  = 2'd2,
      ST_TRAIL = 2'd3
   } rxb_state_e;

   typedef struct packed {
      logic mcast;
      logic phys;
      logic bcast;
   } rxb_kind_t;

   localparam int HDR_OK_BIT    = 0;
   localparam int HDR_BCAST_BIT = 13;
   localparam int HDR_PHYS_BIT  = 14;
   localparam int HDR_MCAST_BIT = 15;
   localparam logic [31:0] CRC_POLY = 32'hEDB88320;

   function automatic logic [31:0] make_header(input logic [15:0] len_plus4,
                                               input rxb_kind_t kind);
      logic [31:0] h;
      h = '0;
      h[HDR_OK_BIT]    = 1'b1;
      h[HDR_BCAST_BIT] = kind.bcast;
      h[HDR_PHYS_BIT]  = kind.phys;
      h[HDR_MCAST_BIT] = kind.mcast;
      h[31:16]         = len_plus4;
      return h;
   endfunction

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'd0, d};
      for (int k = 0; k < 8; k++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/rxb_space_chk.sv
module rxb_space_chk #(
   parameter int PTR_W = 13,
   parameter int LEN_W = 12
) (
   input  logic [PTR_W-1:0] wr,
   input  logic [PTR_W-1:0] rd,
   input  logic [LEN_W-1:0] len,
   output logic [PTR_W-1:0] avail,
   output logic             drop
);
   localparam int CW = ((LEN_W > PTR_W) ? LEN_W : PTR_W) + 1;

   logic [CW-1:0] need;

   // power-of-two ring: the subtraction wraps by itself
   assign avail = rd - wr;
   assign need  = CW'(len) + CW'(8);
   assign drop  = (avail != '0) && (need >= CW'(avail));

endmodule

// File: rtl/rxb_ptr_step.sv
module rxb_ptr_step #(
   parameter int PTR_W = 13
) (
   input  logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] plus1,
   output logic [PTR_W-1:0] plus4,
   output logic [PTR_W-1:0] align1
);
   logic [PTR_W-1:0] bump;

   assign plus1  = ptr + PTR_W'(1);
   assign plus4  = ptr + PTR_W'(4);
   assign bump   = plus1 + PTR_W'(3);
   assign align1 = {bump[PTR_W-1:2], 2'b00};

endmodule

// File: rtl/rxb_trailer_gen.sv
module rxb_trailer_gen #(
   parameter bit CRC_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] word
);
   import rxb_pkg::*;

   generate
      if (CRC_EN) begin : g_crc
         logic [31:0] crc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     crc_q <= '1;
            else if (clear) crc_q <= '1;
            else if (en)    crc_q <= crc_step(crc_q, din);
         end
         assign word = ~crc_q;
      end else begin : g_zero
         logic unused_in;
         assign unused_in = ^{clk, rst_n, clear, en, din};
         assign word = '0;
      end
   endgenerate

endmodule

// File: rtl/rxb_ring_writer.sv
module rxb_ring_writer
   import rxb_pkg::*;
#(
   parameter int BUF_BYTES = 8192,
   parameter int LEN_W     = 12,
   parameter int MISS_W    = 16,
   parameter bit CRC_EN    = 1'b1,
   localparam int PTR_W    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic              frm_start,
   input  logic [LEN_W-1:0]  frm_len,
   input  logic [2:0]        frm_kind,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              busy,
   output logic              dat_rdy,
   output logic              mem_we,
   output logic              mem_wide,
   output logic [PTR_W-1:0]  mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [MISS_W-1:0] miss_cnt,
   output logic              irq_rx_ok,
   output logic              irq_rx_ovf
);

   generate
      if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || BUF_BYTES < 16) begin : g_bad_size
         $error("rxb_ring_writer: BUF_BYTES must be a power of two of at least 16");
      end
      if (LEN_W > 15 || LEN_W < 1) begin : g_bad_len
         $error("rxb_ring_writer: LEN_W must lie in 1..15 so that length+4 fits 16 bits");
      end
      if (MISS_W < 1) begin : g_bad_miss
         $error("rxb_ring_writer: MISS_W must be positive");
      end
   endgenerate

   rxb_state_e       state;
   logic [PTR_W-1:0] wr_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt_q;
   rxb_kind_t        kind_q;
   logic [1:0]       tix_q;
   logic [MISS_W-1:0] miss_q;
   logic             ok_q;
   logic             ovf_q;

   logic [PTR_W-1:0] avail;
   logic             drop;
   logic [PTR_W-1:0] p_plus1, p_plus4, p_align;
   logic [31:0]      trail_word;
   logic [31:0]      hdr_word;
   logic             accept;
   logic             take_byte;
   logic             last_byte;

   rxb_space_chk #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_space (
      .wr    (wr_q),
      .rd    (rd_ptr),
      .len   (frm_len),
      .avail (avail),
      .drop  (drop)
   );

   rxb_ptr_step #(.PTR_W(PTR_W)) u_step (
      .ptr    (wr_q),
      .plus1  (p_plus1),
      .plus4  (p_plus4),
      .align1 (p_align)
   );

   assign accept    = (state == ST_IDLE) && frm_start && !drop;
   assign take_byte = (state == ST_DATA) && byte_valid;
   assign last_byte = (cnt_q == len_q - LEN_W'(1));

   rxb_trailer_gen #(.CRC_EN(CRC_EN)) u_trail (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .en    (take_byte),
      .din   (byte_data),
      .word  (trail_word)
   );

   assign hdr_word = make_header(16'(len_q) + 16'd4, kind_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         wr_q   <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
         kind_q <= '0;
         tix_q  <= '0;
         miss_q <= '0;
         ok_q   <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         ok_q  <= 1'b0;
         ovf_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (frm_start) begin
                  if (drop) begin
                     ovf_q  <= 1'b1;
                     miss_q <= miss_q + MISS_W'(1);
                  end else begin
                     len_q  <= frm_len;
                     kind_q <= rxb_kind_t'(frm_kind);
                     state  <= ST_HDR;
                  end
               end
            end
            ST_HDR: begin
               wr_q  <= p_plus4;
               cnt_q <= '0;
               tix_q <= '0;
               state <= (len_q == '0) ? ST_TRAIL : ST_DATA;
            end
            ST_DATA: begin
               if (byte_valid) begin
                  wr_q  <= p_plus1;
                  cnt_q <= cnt_q + LEN_W'(1);
                  if (last_byte) state <= ST_TRAIL;
               end
            end
            ST_TRAIL: begin
               tix_q <= tix_q + 2'd1;
               if (tix_q == 2'd3) begin
                  wr_q  <= p_align;
                  ok_q  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  wr_q <= p_plus1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_wide  = 1'b0;
      mem_wdata = '0;
      unique case (state)
         ST_HDR: begin
            mem_we    = 1'b1;
            mem_wide  = 1'b1;
            mem_wdata = hdr_word;
         end
         ST_DATA: begin
            mem_we    = byte_valid;
            mem_wdata = {24'd0, byte_data};
         end
         ST_TRAIL: begin
            mem_we    = 1'b1;
            mem_wdata = {24'd0, trail_word[8*tix_q +: 8]};
         end
         default: ;
      endcase
   end

   assign mem_addr   = wr_q;
   assign wr_ptr     = wr_q;
   assign busy       = (state != ST_IDLE);
   assign dat_rdy    = (state == ST_DATA);
   assign miss_cnt   = miss_q;
   assign irq_rx_ok  = ok_q;
   assign irq_rx_ovf = ovf_q;

endmodule

// File: rtl/rxb_ring_writer_chk.sv
module rxb_ring_writer_chk #(
   parameter int PTR_W  = 13,
   parameter int MISS_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              dat_rdy,
   input logic              mem_we,
   input logic              mem_wide,
   input logic [PTR_W-1:0]  mem_addr,
   input logic [PTR_W-1:0]  wr_ptr,
   input logic [MISS_W-1:0] miss_cnt,
   input logic              irq_rx_ok,
   input logic              irq_rx_ovf
);

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we);                                                   // R1
   AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_ovf |-> (miss_cnt == MISS_W'($past(miss_cnt) + 1'b1)));        // R2
   AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_rx_ok, irq_rx_ovf}));                                   // R2
   AST_HDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_wide) |-> (mem_addr[1:0] == 2'b00));                  // R4
   AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (wr_ptr[1:0] == 2'b00));                                    // R7
   AST_OK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_ok |-> (!busy && $past(busy)));                                // R8
   AST_RDY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rdy |-> busy);                                                    // R9

endmodule

bind rxb_ring_writer rxb_ring_writer_chk #(.PTR_W(PTR_W), .MISS_W(MISS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .dat_rdy    (dat_rdy),
   .mem_we     (mem_we),
   .mem_wide   (mem_wide),
   .mem_addr   (mem_addr),
   .wr_ptr     (wr_ptr),
   .miss_cnt   (miss_cnt),
   .irq_rx_ok  (irq_rx_ok),
   .irq_rx_ovf (irq_rx_ovf)
);

// File: tb/sim_rxb_ring_writer.sv
module sim_rxb_ring_writer;
   localparam int CLK_PERIOD = 10;
   localparam int SIZE  = 8192;
   localparam int PW    = 13;
   localparam int LW    = 12;
   localparam int MW    = 16;
   localparam int NVEC  = 12;
   localparam int WDOG  = 150000;

   // vector: rd offset(13) | len(12) | kind(3) | gaps(1) | expect drop(1)
   localparam logic [29:0] VEC [NVEC] = '{
      {13'd0,    12'd60,   3'b001, 1'b0, 1'b0},  // empty ring R3
      {13'd100,  12'd92,   3'b000, 1'b0, 1'b1},  // len+8 == avail, drop R2
      {13'd100,  12'd91,   3'b010, 1'b0, 1'b0},  // one to spare
      {13'd8000, 12'd64,   3'b001, 1'b1, 1'b0},
      {13'd20,   12'd0,    3'b100, 1'b0, 1'b0},  // zero-length frame
      {13'd1,    12'd0,    3'b000, 1'b0, 1'b1},
      {13'd0,    12'd1,    3'b010, 1'b1, 1'b0},
      {13'd500,  12'd499,  3'b001, 1'b0, 1'b1},
      {13'd0,    12'd255,  3'b100, 1'b0, 1'b0},
      {13'd2000, 12'd1023, 3'b000, 1'b1, 1'b0},
      {13'd0,    12'd3,    3'b111, 1'b0, 1'b0},
      {13'd8191, 12'd4000, 3'b011, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] rd_ptr = '0;
   logic          frm_start = 1'b0;
   logic [LW-1:0] frm_len = '0;
   logic [2:0]    frm_kind = '0;
   logic          byte_valid = 1'b0;
   logic [7:0]    byte_data = '0;
   logic          busy, dat_rdy, mem_we, mem_wide;
   logic [PW-1:0] mem_addr, wr_ptr;
   logic [31:0]   mem_wdata;
   logic [MW-1:0] miss_cnt;
   logic          irq_rx_ok, irq_rx_ovf;

   int  total = 0;
   int  fails = 0;
   int  cyc = 0;
   int  wr_events = 0;
   bit  finished = 0;
   logic [7:0] mem [SIZE];
   int  model_wr = 0;
   int  model_miss = 0;
   int  seed = 1;

   rxb_ring_writer u0 (
      .clk(clk), .rst_n(rst_n), .rd_ptr(rd_ptr), .frm_start(frm_start),
      .frm_len(frm_len), .frm_kind(frm_kind), .byte_valid(byte_valid),
      .byte_data(byte_data), .busy(busy), .dat_rdy(dat_rdy), .mem_we(mem_we),
      .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .wr_ptr(wr_ptr), .miss_cnt(miss_cnt), .irq_rx_ok(irq_rx_ok),
      .irq_rx_ovf(irq_rx_ovf)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) begin
         wr_events <= wr_events + 1;
         if (mem_wide) begin
            for (int k = 0; k < 4; k++)
               mem[(int'(mem_addr) + k) % SIZE] <= mem_wdata[8*k +: 8];
         end else begin
            mem[int'(mem_addr)] <= mem_wdata[7:0];
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WDOG && !finished) begin
         total = total + 1;
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WDOG);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int s, input int i);
      return 8'((s * 13 + i * 7) & 8'hFF);
   endfunction

   function automatic logic [31:0] ref_crc(input int s, input int n);
      logic [31:0] c;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'd0, pat(s, i)};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   function automatic logic [31:0] rd_word(input int a);
      return {mem[(a + 3) % SIZE], mem[(a + 2) % SIZE], mem[(a + 1) % SIZE], mem[a % SIZE]};
   endfunction

   task automatic run_frame(input int rd_off, input int len, input logic [2:0] kind,
                            input bit gaps, input bit exp_drop, input bit junk);
      int base, ev0, bad_i;
      logic [31:0] hdr_exp;
      bit data_ok;
      rd_ptr    = PW'((model_wr + rd_off) % SIZE);
      base      = model_wr;
      ev0       = wr_events;
      seed      = seed + 1;
      frm_start = 1'b1;
      frm_len   = LW'(len);
      frm_kind  = kind;
      @(negedge clk);
      if (junk) begin
         frm_len    = LW'(len + 40);
         frm_kind   = ~kind;
         byte_valid = 1'b1;
         byte_data  = 8'hEE;
         @(negedge clk);
         byte_valid = 1'b0;
      end
      frm_start = 1'b0;
      if (exp_drop) begin
         model_miss = model_miss + 1;
         chk(irq_rx_ovf == 1'b1, "R2", "overflow pulse", 32'(irq_rx_ovf), 1);
         chk(miss_cnt == MW'(model_miss), "R2", "missed count", 32'(miss_cnt), 32'(model_miss));
         chk(wr_events == ev0 && !busy, "R2", "no write on drop", 32'(wr_events - ev0), 0);
         chk(wr_ptr == PW'(model_wr), "R2", "pointer kept on drop", 32'(wr_ptr), 32'(model_wr));
         @(negedge clk);
         chk(irq_rx_ovf == 1'b0, "R2", "overflow pulse width", 32'(irq_rx_ovf), 0);
         return;
      end
      for (int i = 0; i < len; i++) begin
         if (gaps && (i % 3 == 2)) begin
            byte_valid = 1'b0;
            @(negedge clk);
         end
         while (!dat_rdy) @(negedge clk);
         byte_valid = 1'b1;
         byte_data  = pat(seed, i);
         @(negedge clk);
      end
      byte_valid = 1'b0;
      while (busy) @(negedge clk);
      chk(irq_rx_ok == 1'b1, "R8", "receive-OK pulse", 32'(irq_rx_ok), 1);
      hdr_exp = {16'(len + 4), kind[2], kind[1], kind[0], 12'd0, 1'b1};
      chk(rd_word(base) == hdr_exp, "R4", "header word", rd_word(base), hdr_exp);
      data_ok = 1'b1;
      bad_i = 0;
      for (int i = 0; i < len; i++) begin
         if (data_ok && mem[(base + 4 + i) % SIZE] != pat(seed, i)) begin
            data_ok = 1'b0;
            bad_i = i;
         end
      end
      chk(data_ok, "R5", "frame bytes", 32'(mem[(base + 4 + bad_i) % SIZE]),
          32'(pat(seed, bad_i)));
      chk(rd_word(base + 4 + len) == ref_crc(seed, len), "R6", "check word",
          rd_word(base + 4 + len), ref_crc(seed, len));
      model_wr = (((base + len + 8) + 3) / 4 * 4) % SIZE;
      chk(wr_ptr == PW'(model_wr), "R7", "aligned write pointer", 32'(wr_ptr), 32'(model_wr));
      @(negedge clk);
      chk(irq_rx_ok == 1'b0, "R8", "receive-OK pulse width", 32'(irq_rx_ok), 0);
   endtask

   task automatic advance_near_end();
      while (!(model_wr >= SIZE - 1600 && model_wr <= SIZE - 16))
         run_frame(0, 1500, 3'b000, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(wr_ptr == '0, "R1", "reset write pointer", 32'(wr_ptr), 0);
      chk(miss_cnt == '0, "R1", "reset missed count", 32'(miss_cnt), 0);
      chk(!busy && !mem_we, "R1", "reset idle", 32'({busy, mem_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         run_frame(int'(VEC[v][29:17]), int'(VEC[v][16:5]), VEC[v][4:2],
                   VEC[v][1], VEC[v][0], 1'b0);
      end

      // R3: read pointer equal to write pointer, long frame still accepted
      run_frame(0, 4000, 3'b001, 1'b0, 1'b0, 1'b0);

      // R9: start and byte strobes during the header cycle are ignored
      run_frame(0, 10, 3'b010, 1'b0, 1'b0, 1'b1);

      // R5: frame bytes cross the ring end
      advance_near_end();
      run_frame(0, SIZE - model_wr - 4 + 100, 3'b100, 1'b1, 1'b0, 1'b0);

      // R6: check word crosses the ring end
      advance_near_end();
      run_frame(0, SIZE - model_wr - 6, 3'b001, 1'b0, 1'b0, 1'b0);

      // R2: drop at the exact limit after a wrap
      run_frame(40, 32, 3'b000, 1'b0, 1'b1, 1'b0);
      run_frame(40, 31, 3'b000, 1'b0, 1'b0, 1'b0);

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule